// File: doc/BRIEF.md
# Ethernet Receive Frame Acceptance Filter

This block sits beside a receive MAC and watches each incoming frame byte by byte. It collects the destination address and the frame length, and it folds the destination bytes into a running CRC-32 to pick one bit from a multicast hash table. When the last byte arrives it weighs the address class, the length and the error flags against six enable bits, and decides whether the frame is kept. It then pulses an accept strobe and, unless monitoring only, a store strobe for the buffer writer. It also publishes a status byte and keeps three saturating tallies for the host.

Bytes enter on a valid/ready stream. `rx_ready` is held high at all times, so a beat is consumed on every rising edge where `rx_valid` is high. The source may insert idle cycles anywhere, and the filter never applies back-pressure. A beat belongs to a frame only if it carries `rx_sof` or follows a start beat whose frame has not yet ended. The error flags are sampled on the end beat only.

Top module: `rxf_accept_filter`

## Requirements
- R1: With `rx_cfg[0]` (keep-errored) clear, a frame whose end beat carries `rx_crc_err` or `rx_align_err` is rejected. With it set, the error flags do not block acceptance.
- R2: With `rx_cfg[1]` (keep-short) clear, a frame of fewer than 64 bytes is rejected. With it set, length does not block acceptance.
- R3: A destination of all ones is accepted only when `rx_cfg[2]` is set. This test takes precedence over the multicast test.
- R4: Any other destination whose first byte has bit 0 set is a group address. It passes only when `rx_cfg[3]` is set and the hash table bit is one. That bit is selected by bits 31..26 of a reflected CRC-32 (polynomial 0xEDB88320, preset all ones, no final inversion, each byte taken LSB first) run over the six destination bytes.
- R5: An individual destination passes when `rx_cfg[4]` (promiscuous) is set or when it equals `station_addr`. Byte k of the address, in arrival order, is held in bits 8k+7..8k. Frames shorter than six bytes never pass the address test.
- R6: `accept` and `store` are single-cycle pulses in the cycle after the end beat. `accept` marks a frame passing the address, length and error tests. `store` equals `accept` with `rx_cfg[5]` clear.
- R7: With `rx_cfg[5]` (monitor) set, `store` stays low, and each frame that would be accepted increments `miss_tally`.
- R8: `status` becomes zero in the cycle after a start beat and is loaded in the cycle after the end beat. Its bits are: 7 broadcast, 6 station match, 5 short, 4 group, 3 missed (monitor accept), 2 alignment error, 1 CRC error, 0 accepted. It holds its value until the next start beat.
- R9: `crc_tally` and `align_tally` count every frame end that carries the corresponding flag, whether or not the frame is accepted. All tallies are 8 bits wide and stop at 255.
- R10: `tally_clr` zeroes all three tallies on the next edge. When it coincides with an increment, the clear wins.
- R11: Beats outside a frame (valid without a start beat and with no open frame) change no output, and `rx_ready` is always high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Byte beat valid |
| rx_ready | output | 1 | Always high; the filter never stalls |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_data | input | 8 | Frame byte |
| rx_crc_err | input | 1 | Frame check error, sampled on the end beat |
| rx_align_err | input | 1 | Alignment error, sampled on the end beat |
| rx_cfg | input | 6 | Acceptance enables: 0 keep-errored, 1 keep-short, 2 broadcast, 3 multicast, 4 promiscuous, 5 monitor |
| station_addr | input | 48 | Station address, byte k in bits 8k+7..8k |
| hash_table | input | 64 | Multicast hash bits |
| tally_clr | input | 1 | Synchronous clear of all tallies |
| accept | output | 1 | Frame accepted pulse |
| store | output | 1 | Write-to-memory pulse |
| status | output | 8 | Receive status byte |
| crc_tally | output | 8 | CRC error count |
| align_tally | output | 8 | Alignment error count |
| miss_tally | output | 8 | Monitor-mode missed count |

## Verification
A tally clear and a tally increment can fall in the same cycle. This happens when `tally_clr` is raised on the very beat that ends an errored frame, which would otherwise bump the CRC tally. The bench drives exactly that overlap and expects all three counters to read zero afterwards. The rest of the run sweeps every configuration against every address class, two lengths and three error patterns. For each frame it compares the strobes, the status byte and the running tallies with values computed from the rules above.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  typedef struct packed {
    logic monitor;
    logic promisc;
    logic mcast_en;
    logic bcast_en;
    logic short_en;
    logic keep_err;
  } rxf_cfg_t;

  localparam int ST_OK     = 0;
  localparam int ST_CRC    = 1;
  localparam int ST_ALIGN  = 2;
  localparam int ST_MISSED = 3;
  localparam int ST_GROUP  = 4;
  localparam int ST_SHORT  = 5;
  localparam int ST_PHYS   = 6;
  localparam int ST_BCAST  = 7;

  localparam int TALLY_CRC   = 0;
  localparam int TALLY_ALIGN = 1;
  localparam int TALLY_MISS  = 2;
  localparam int TALLY_NUM   = 3;

  function automatic logic [31:0] crc32_step(input logic [31:0] c_in, input logic [7:0] b);
    logic [31:0] c;
    c = c_in ^ {24'd0, b};
    for (int k = 0; k < 8; k++) begin
      c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/rxf_dest_track.sv
module rxf_dest_track #(
  parameter int ADDR_BYTES = 6,
  parameter int LEN_W      = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    beat,
  input  logic                    sof,
  input  logic [7:0]              data,
  output logic [8*ADDR_BYTES-1:0] dest_now,
  output logic [LEN_W-1:0]        len_now,
  output logic                    dest_done,
  output logic                    in_dest
);
  localparam logic [LEN_W-1:0] LEN_MAX   = '1;
  localparam logic [LEN_W-1:0] ADDR_LEN  = LEN_W'(ADDR_BYTES);

  logic [8*ADDR_BYTES-1:0] dest_q;
  logic [LEN_W-1:0]        len_q;
  logic [LEN_W-1:0]        base_len;

  assign base_len = sof ? '0 : len_q;
  assign in_dest  = beat && (base_len < ADDR_LEN);

  always_comb begin
    if (!beat)                  len_now = len_q;
    else if (base_len == LEN_MAX) len_now = base_len;
    else                        len_now = base_len + 1'b1;
  end

  assign dest_done = len_now >= ADDR_LEN;

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_byte
    assign dest_now[g*8 +: 8] = (in_dest && base_len == LEN_W'(g)) ? data : dest_q[g*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dest_q <= '0;
      len_q  <= '0;
    end else if (beat) begin
      dest_q <= dest_now;
      len_q  <= len_now;
    end
  end

  p_len_grows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !sof && len_q != LEN_MAX) |=> len_q == $past(len_q) + 1'b1);

endmodule

// File: rtl/rxf_hash_index.sv
module rxf_hash_index #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_dest,
  input  logic             sof,
  input  logic [7:0]       data,
  output logic [IDX_W-1:0] index
);
  import rxf_pkg::*;

  logic [31:0] crc_q;
  logic [31:0] crc_now;
  logic [31:0] crc_seed;

  assign crc_seed = sof ? 32'hFFFF_FFFF : crc_q;
  assign crc_now  = in_dest ? crc32_step(crc_seed, data) : crc_q;
  assign index    = crc_now[31 -: IDX_W];

  always_ff @(posedge clk) begin
    if (!rst_n)       crc_q <= 32'hFFFF_FFFF;
    else if (in_dest) crc_q <= crc_now;
  end

  p_crc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !in_dest |=> $stable(crc_q));

endmodule

// File: rtl/rxf_tally.sv
module rxf_tally #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)                  count <= '0;
    else if (clr)                count <= '0;
    else if (inc && count != TOP) count <= count + 1'b1;
  end

  p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr) |-> count >= $past(count));
  p_clear_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> count == '0);

endmodule

// File: rtl/rxf_accept_filter.sv
module rxf_accept_filter #(
  parameter int ADDR_BYTES = 6,
  parameter int LEN_W      = 12,
  parameter int MIN_LEN    = 64,
  parameter int IDX_W      = 6,
  parameter int TALLY_W    = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rx_valid,
  output logic                    rx_ready,
  input  logic                    rx_sof,
  input  logic                    rx_eof,
  input  logic [7:0]              rx_data,
  input  logic                    rx_crc_err,
  input  logic                    rx_align_err,
  input  logic [5:0]              rx_cfg,
  input  logic [8*ADDR_BYTES-1:0] station_addr,
  input  logic [(1<<IDX_W)-1:0]   hash_table,
  input  logic                    tally_clr,
  output logic                    accept,
  output logic                    store,
  output logic [7:0]              status,
  output logic [TALLY_W-1:0]      crc_tally,
  output logic [TALLY_W-1:0]      align_tally,
  output logic [TALLY_W-1:0]      miss_tally
);
  import rxf_pkg::*;

  localparam logic [LEN_W-1:0] SHORT_LIM = LEN_W'(MIN_LEN);

  rxf_cfg_t cfg;
  assign cfg      = rxf_cfg_t'(rx_cfg);
  assign rx_ready = 1'b1;

  logic in_frame_q;
  logic beat, end_beat;
  assign beat     = rx_valid && (rx_sof || in_frame_q);
  assign end_beat = beat && rx_eof;

  always_ff @(posedge clk) begin
    if (!rst_n)    in_frame_q <= 1'b0;
    else if (beat) in_frame_q <= !rx_eof;
  end

  logic [8*ADDR_BYTES-1:0] dest_now;
  logic [LEN_W-1:0]        len_now;
  logic                    dest_done, in_dest;
  logic [IDX_W-1:0]        hidx;

  rxf_dest_track #(.ADDR_BYTES(ADDR_BYTES), .LEN_W(LEN_W)) u_track (
    .clk(clk), .rst_n(rst_n), .beat(beat), .sof(rx_sof), .data(rx_data),
    .dest_now(dest_now), .len_now(len_now), .dest_done(dest_done), .in_dest(in_dest)
  );

  rxf_hash_index #(.IDX_W(IDX_W)) u_hash (
    .clk(clk), .rst_n(rst_n), .in_dest(in_dest), .sof(rx_sof), .data(rx_data),
    .index(hidx)
  );

  // Classification of the frame that ends on this beat
  logic is_bcast, is_group, is_phys, addr_ok, is_short, has_err, would_take;
  assign is_bcast = dest_done && (&dest_now);
  assign is_group = dest_done && dest_now[0];
  assign is_phys  = dest_done && (dest_now == station_addr);

  always_comb begin
    if (!dest_done)    addr_ok = 1'b0;
    else if (is_bcast) addr_ok = cfg.bcast_en;
    else if (is_group) addr_ok = cfg.mcast_en && hash_table[hidx];
    else               addr_ok = cfg.promisc || is_phys;
  end

  assign is_short   = len_now < SHORT_LIM;
  assign has_err    = rx_crc_err || rx_align_err;
  assign would_take = addr_ok && (!is_short || cfg.short_en) && (!has_err || cfg.keep_err);

  logic [7:0] status_new;
  always_comb begin
    status_new            = '0;
    status_new[ST_OK]     = would_take;
    status_new[ST_CRC]    = rx_crc_err;
    status_new[ST_ALIGN]  = rx_align_err;
    status_new[ST_MISSED] = would_take && cfg.monitor;
    status_new[ST_GROUP]  = is_group;
    status_new[ST_SHORT]  = is_short;
    status_new[ST_PHYS]   = is_phys;
    status_new[ST_BCAST]  = is_bcast;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      accept <= 1'b0;
      store  <= 1'b0;
      status <= '0;
    end else begin
      accept <= end_beat && would_take;
      store  <= end_beat && would_take && !cfg.monitor;
      if (end_beat)          status <= status_new;
      else if (beat && rx_sof) status <= '0;
    end
  end

  logic [TALLY_NUM-1:0] tally_inc;
  logic [TALLY_W-1:0]   tally_val [TALLY_NUM];
  assign tally_inc[TALLY_CRC]   = end_beat && rx_crc_err;
  assign tally_inc[TALLY_ALIGN] = end_beat && rx_align_err;
  assign tally_inc[TALLY_MISS]  = end_beat && would_take && cfg.monitor;

  for (genvar t = 0; t < TALLY_NUM; t++) begin : g_tally
    rxf_tally #(.W(TALLY_W)) u_tally (
      .clk(clk), .rst_n(rst_n), .clr(tally_clr), .inc(tally_inc[t]), .count(tally_val[t])
    );
  end

  assign crc_tally   = tally_val[TALLY_CRC];
  assign align_tally = tally_val[TALLY_ALIGN];
  assign miss_tally  = tally_val[TALLY_MISS];

  p_store_with_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    store |-> accept);
  p_strobe_after_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> $past(end_beat));
  p_monitor_no_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
    store |-> !$past(cfg.monitor));
  p_short_blocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !$past(cfg.short_en)) |-> !status[ST_SHORT]);
  p_err_blocked_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !$past(cfg.keep_err)) |-> !status[ST_CRC] && !status[ST_ALIGN]);
  p_status_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && rx_sof && !rx_eof) |=> status == '0);
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!beat) |=> !accept && $stable(status));

endmodule

// File: tb/rxf_accept_filter_bench.sv
module rxf_accept_filter_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        rx_valid = 0, rx_sof = 0, rx_eof = 0, rx_crc_err = 0, rx_align_err = 0;
  logic [7:0]  rx_data = 0;
  logic [5:0]  rx_cfg = 0;
  logic        tally_clr = 0;
  logic        rx_ready, accept, store;
  logic [7:0]  status, crc_tally, align_tally, miss_tally;
  logic [47:0] station_addr = {8'h55, 8'h44, 8'h33, 8'h22, 8'h11, 8'h02};
  logic [63:0] hash_table   = 64'hA5C3_0F96_3C5A_E187;

  rxf_accept_filter u_rxf_accept_filter (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_data(rx_data),
    .rx_crc_err(rx_crc_err), .rx_align_err(rx_align_err), .rx_cfg(rx_cfg),
    .station_addr(station_addr), .hash_table(hash_table), .tally_clr(tally_clr),
    .accept(accept), .store(store), .status(status),
    .crc_tally(crc_tally), .align_tally(align_tally), .miss_tally(miss_tally)
  );

  int checks = 0;
  int errors = 0;
  int m_crc = 0, m_align = 0, m_miss = 0;
  logic [47:0] addr_kind [5];

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int hash_idx(input logic [47:0] d);
    logic [31:0] c;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < 6; i++) begin
      c = c ^ {24'd0, d[8*i +: 8]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
    end
    return int'(c[31:26]);
  endfunction

  function automatic int sat(input int v);
    return (v > 255) ? 255 : v;
  endfunction

  task automatic run_frame(input logic [47:0] dst, input int len, input bit ce,
                           input bit ae, input bit clr_end);
    bit bc, grp, phys, aok, shrt, take;
    int exp_status;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid     = 1;
      rx_sof       = (i == 0);
      rx_eof       = (i == len - 1);
      rx_data      = (i < 6) ? dst[8*i +: 8] : (8'(i) ^ 8'h5A);
      rx_crc_err   = (i == len - 1) && ce;
      rx_align_err = (i == len - 1) && ae;
      tally_clr    = (i == len - 1) && clr_end;
    end
    @(negedge clk);
    rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_crc_err = 0; rx_align_err = 0; tally_clr = 0;
    bc   = (dst == '1);
    grp  = dst[0];
    phys = (dst == station_addr);
    if (bc)       aok = rx_cfg[2];
    else if (grp) aok = rx_cfg[3] && hash_table[hash_idx(dst)];
    else          aok = rx_cfg[4] || phys;
    shrt = len < 64;
    take = aok && (!shrt || rx_cfg[1]) && (!(ce || ae) || rx_cfg[0]);
    exp_status = {24'd0, bc, phys, shrt, grp, take && rx_cfg[5], ae, ce, take};
    // R1 R2 R3 R4 R5: acceptance decision
    chk("R1-R5 accept", int'(accept), int'(take));
    // R6 R7: store follows accept unless monitoring
    chk("R6/R7 store", int'(store), int'(take && !rx_cfg[5]));
    chk("R8 status", int'(status), exp_status);
    if (clr_end) begin
      m_crc = 0; m_align = 0; m_miss = 0;
    end else begin
      m_crc   = sat(m_crc + int'(ce));
      m_align = sat(m_align + int'(ae));
      m_miss  = sat(m_miss + int'(take && rx_cfg[5]));
    end
    chk("R9 crc_tally", int'(crc_tally), m_crc);
    chk("R9 align_tally", int'(align_tally), m_align);
    chk("R7 miss_tally", int'(miss_tally), m_miss);
    @(negedge clk);
    chk("R6 accept pulse", int'(accept), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int hit_k, miss_k;
    logic [47:0] cand;
    hit_k = -1; miss_k = -1;
    for (int k = 0; k < 256; k++) begin
      cand = {8'(k), 8'h00, 8'h00, 8'h5E, 8'h00, 8'h01};
      if (hash_table[hash_idx(cand)] && hit_k < 0) hit_k = k;
      if (!hash_table[hash_idx(cand)] && miss_k < 0) miss_k = k;
    end
    addr_kind[0] = '1;
    addr_kind[1] = {8'(hit_k), 8'h00, 8'h00, 8'h5E, 8'h00, 8'h01};
    addr_kind[2] = {8'(miss_k), 8'h00, 8'h00, 8'h5E, 8'h00, 8'h01};
    addr_kind[3] = station_addr;
    addr_kind[4] = {8'h56, 8'h44, 8'h33, 8'h22, 8'h11, 8'h02};

    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk("R6 reset accept", int'(accept), 0);
    chk("R6 reset store", int'(store), 0);
    chk("R8 reset status", int'(status), 0);
    chk("R9 reset crc_tally", int'(crc_tally), 0);
    chk("R11 ready", int'(rx_ready), 1);

    for (int cfg = 0; cfg < 64; cfg++) begin
      rx_cfg = 6'(cfg);
      for (int a = 0; a < 5; a++)
        for (int l = 0; l < 2; l++)
          for (int e = 0; e < 3; e++)
            run_frame(addr_kind[a], l ? 64 : 8, e == 1, e == 2, 1'b0);
    end

    // R10: clear coinciding with a CRC-tally increment
    rx_cfg = 6'b111111;
    run_frame(addr_kind[0], 64, 1'b1, 1'b0, 1'b1);
    chk("R10 clear wins crc", int'(crc_tally), 0);
    run_frame(addr_kind[0], 64, 1'b0, 1'b1, 1'b0);
    chk("R10 count after clear", int'(align_tally), 1);

    // R11: beats with no open frame are ignored
    begin
      logic [7:0] st_before;
      st_before = status;
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        rx_valid = 1; rx_sof = 0; rx_eof = (i == 2); rx_data = 8'hFF;
        rx_crc_err = (i == 2);
      end
      @(negedge clk);
      rx_valid = 0; rx_eof = 0; rx_crc_err = 0;
      chk("R11 stray accept", int'(accept), 0);
      chk("R11 stray status", int'(status), int'(st_before));
      chk("R11 stray crc_tally", int'(crc_tally), m_crc);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule